// File: doc/BRIEF.md
# Multi-Line I2S Slave Channel Framer

This block sits between an I2S-style audio bus and a word-parallel audio path. It never makes bus clocks: the bit clock and the word-select clock come in from a bus master, and all logic runs on the incoming bit clock. Each audio slot is 32 bits wide, MSB first, with one bit of delay after each word-select edge. A frame starts when word select falls. The block gathers the received bits into eight 32-bit channel words. Once per frame it presents all eight at once with a one-cycle strobe.

A static mode input picks the lane layout. In serial mode, line 0 carries all eight channels in turn. In parallel mode, each of the four lines carries two channels, one per word-select phase. The transmit side works the same way in reverse. Eight parallel words are latched at each frame boundary and shifted out on the following frame. Each channel's transmitted data can be forced to zero by its own mute bit. A single enable bit switches the output pads between driving and high impedance. A drive-strength bit is passed straight through for the pad ring.

Top module: `i2sChannelFramer`

## Requirements
- R1: While `rstN` is low, `rxWords` is all zero, `frameValid` is 0 and `sdOut` is 0. No strobe occurs before a full frame has been received after the first observed falling edge of `ws`.
- R2: A frame begins at the bit-clock rising edge that first sees `ws` low after it was high. The bit sampled at that edge is the last bit of the previous frame. Each following rising edge samples one bit, 32 per slot, MSB first.
- R3: In serial mode (`parMode`=0), line 0 carries channels 0..7 in slot order: channels 0..3 while `ws` is low, channels 4..7 while it is high. Lines 1..3 of `sdIn` are ignored. Channel c sits at `rxWords[32c+31:32c]`.
- R4: In parallel mode (`parMode`=1), line l carries channel 2l while `ws` is low and channel 2l+1 while `ws` is high.
- R5: `frameValid` is high for exactly one cycle. That cycle follows the rising edge that samples a frame's last bit. At that edge `rxWords` changes to hold all eight words of that frame, and it does not change at any other time.
- R6: At the frame boundary the block latches `txWords`, using the same channel-to-slot layout. It sends these words during the next frame. Each bit is launched on a falling edge of `bclk`, so that it is valid at the rising edge where the receiver samples the same slot position.
- R7: When mute bit `cfgWord[2+c]` is set at a frame boundary, every bit of channel c in the frame that follows is sent as zero.
- R8: When `cfgWord[0]`=0, `sdOutEn` is 0000 and `sdOut` is 0000 at once. When it is 1, `sdOutEn` is 1111.
- R9: `driveStrong` always equals `cfgWord[1]`.
- R10: In serial mode, `sdOut[3:1]` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus bit clock from the master; sole clock of the block |
| rstN | input | 1 | Active-low asynchronous reset |
| ws | input | 1 | Word-select (frame) clock from the master |
| sdIn | input | 4 | Serial data input lines |
| parMode | input | 1 | 0 = eight channels on line 0, 1 = two channels per line; change only in reset |
| cfgWord | input | 10 | [0] output enable, [1] drive strength, [9:2] per-channel mute |
| txWords | input | 256 | Eight words to transmit, channel c at bits 32c+31:32c |
| rxWords | output | 256 | Eight received words of the last complete frame |
| frameValid | output | 1 | One-cycle strobe when rxWords is refreshed |
| sdOut | output | 4 | Serial data output lines |
| sdOutEn | output | 4 | Per-line pad drive enable; 0 means high impedance |
| driveStrong | output | 1 | Pad drive-strength select |

## Verification
Suppose the bit counter slips or the word-select edge is taken from the wrong clock. The words in `rxWords` then come out rotated or bit-shifted by the next strobe, at most one frame later. The same fault makes `sdOut` go wrong within one bit time of the following frame, so each output bit is compared on every clock. A lane or slot mapping fault puts one channel's pattern where another's belongs, and the edge-case data (all ones, all zeros, end bits only) shows it. A latch that stores the transmit words or mute mask at the wrong time shows up as a frame whose muting or data does not match the values set during the frame before.

// File: rtl/i2sFramerPkg.sv
package i2sFramerPkg;

  // strobes sent from the sequencing logic to the datapath
  typedef struct packed {
    logic wordDone;  // current edge samples the last bit of a slot
    logic commit;    // frame complete: publish staged words
    logic loadTx;    // frame boundary: latch transmit words
  } frameStrobes_t;

endpackage

// File: rtl/i2sFramerCtrl.sv
module i2sFramerCtrl
  import i2sFramerPkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int LINES     = 4,
  parameter int SLOT_BITS = 32,
  parameter int IDX_W     = 8,
  parameter int SLOT_W    = 5
) (
  input  logic              bclk,
  input  logic              rstN,
  input  logic              ws,
  input  logic              parMode,
  output frameStrobes_t     strb,
  output logic [IDX_W-1:0]  rxIdx,
  output logic [IDX_W-1:0]  txIdx,
  output logic              frameValid
);

  localparam int CPL = CHANNELS / LINES;
  localparam logic [IDX_W-1:0] SER_LAST = IDX_W'(CHANNELS * SLOT_BITS - 1);
  localparam logic [IDX_W-1:0] PAR_LAST = IDX_W'(CPL * SLOT_BITS - 1);

  logic             wsDly;
  logic             fallDet;
  logic             synced;
  logic [IDX_W-1:0] bitCnt;

  assign fallDet = wsDly & ~ws;

  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      wsDly      <= 1'b0;
      synced     <= 1'b0;
      bitCnt     <= '0;
      frameValid <= 1'b0;
    end else begin
      wsDly      <= ws;
      synced     <= synced | fallDet;
      bitCnt     <= fallDet ? '0 : bitCnt + 1'b1;
      frameValid <= fallDet & synced;
    end
  end

  // index of the bit sampled at this rising edge
  assign rxIdx = fallDet ? (parMode ? PAR_LAST : SER_LAST) : bitCnt;
  // index of the bit launched at the coming falling edge
  assign txIdx = bitCnt;

  always_comb begin
    strb.wordDone = (rxIdx[SLOT_W-1:0] == {SLOT_W{1'b1}});
    strb.commit   = fallDet & synced;
    strb.loadTx   = fallDet;
  end

endmodule

// File: rtl/i2sFramerDatapath.sv
module i2sFramerDatapath
  import i2sFramerPkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int LINES     = 4,
  parameter int SLOT_BITS = 32,
  parameter int IDX_W     = 8,
  parameter int SLOT_W    = 5,
  parameter int CH_W      = 3
) (
  input  logic                          bclk,
  input  logic                          rstN,
  input  logic                          parMode,
  input  frameStrobes_t                 strb,
  input  logic [IDX_W-1:0]              rxIdx,
  input  logic [IDX_W-1:0]              txIdx,
  input  logic [LINES-1:0]              sdIn,
  input  logic [CHANNELS*SLOT_BITS-1:0] txWords,
  input  logic [CHANNELS-1:0]           muteMask,
  input  logic                          outEnable,
  output logic [CHANNELS*SLOT_BITS-1:0] rxWords,
  output logic [LINES-1:0]              sdOut,
  output logic [LINES-1:0]              sdOutEn
);

  localparam int CPL = CHANNELS / LINES;

  logic [SLOT_BITS-1:0] shReg    [LINES];
  logic [SLOT_BITS-1:0] lineWord [LINES];
  logic [SLOT_BITS-1:0] txHold   [CHANNELS];
  logic [CH_W-1:0]      rxSlot;
  logic [CH_W-1:0]      txSlot;
  logic [SLOT_W-1:0]    txBit;
  logic [LINES-1:0]     nextBit;
  logic [LINES-1:0]     sdBit;

  assign rxSlot = rxIdx[IDX_W-1:SLOT_W];
  assign txSlot = txIdx[IDX_W-1:SLOT_W];
  assign txBit  = ~txIdx[SLOT_W-1:0];

  // receive shifters, one per line
  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge bclk or negedge rstN) begin
      if (!rstN) shReg[l] <= '0;
      else       shReg[l] <= {shReg[l][SLOT_BITS-2:0], sdIn[l]};
    end
    assign lineWord[l] = {shReg[l][SLOT_BITS-2:0], sdIn[l]};
  end

  // per-channel staging and published words
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    localparam int              PLINE = c / CPL;
    localparam logic [CH_W-1:0] PSLOT = CH_W'(c % CPL);
    localparam logic [CH_W-1:0] SSLOT = CH_W'(c);
    logic                 hit;
    logic [SLOT_BITS-1:0] word;
    logic [SLOT_BITS-1:0] stage;
    logic [SLOT_BITS-1:0] pub;

    assign hit  = strb.wordDone && (parMode ? (rxSlot == PSLOT) : (rxSlot == SSLOT));
    assign word = parMode ? lineWord[PLINE] : lineWord[0];

    always_ff @(posedge bclk or negedge rstN) begin
      if (!rstN) begin
        stage <= '0;
        pub   <= '0;
      end else begin
        if (hit)         stage <= word;
        if (strb.commit) pub   <= hit ? word : stage;
      end
    end
    assign rxWords[c*SLOT_BITS +: SLOT_BITS] = pub;
  end

  // transmit words latched at the frame boundary, mute applied here
  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CHANNELS; c++) txHold[c] <= '0;
    end else if (strb.loadTx) begin
      for (int c = 0; c < CHANNELS; c++)
        txHold[c] <= muteMask[c] ? '0 : txWords[c*SLOT_BITS +: SLOT_BITS];
    end
  end

  // bit selection per line
  always_comb begin
    nextBit = '0;
    if (parMode) begin
      for (int l = 0; l < LINES; l++) begin
        if (txSlot < CH_W'(CPL))
          nextBit[l] = txHold[CH_W'(l * CPL) + txSlot][txBit];
      end
    end else begin
      nextBit[0] = txHold[txSlot][txBit];
    end
  end

  // launch on the falling edge
  always_ff @(negedge bclk or negedge rstN) begin
    if (!rstN) sdBit <= '0;
    else       sdBit <= nextBit;
  end

  assign sdOut   = outEnable ? sdBit : '0;
  assign sdOutEn = {LINES{outEnable}};

endmodule

// File: rtl/i2sChannelFramer.sv
module i2sChannelFramer
  import i2sFramerPkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int LINES     = 4,
  parameter int SLOT_BITS = 32
) (
  input  logic                          bclk,
  input  logic                          rstN,
  input  logic                          ws,
  input  logic [LINES-1:0]              sdIn,
  input  logic                          parMode,
  input  logic [CHANNELS+1:0]           cfgWord,
  input  logic [CHANNELS*SLOT_BITS-1:0] txWords,
  output logic [CHANNELS*SLOT_BITS-1:0] rxWords,
  output logic                          frameValid,
  output logic [LINES-1:0]              sdOut,
  output logic [LINES-1:0]              sdOutEn,
  output logic                          driveStrong
);

  localparam int IDX_W  = $clog2(CHANNELS * SLOT_BITS);
  localparam int SLOT_W = $clog2(SLOT_BITS);
  localparam int CH_W   = $clog2(CHANNELS);

  frameStrobes_t    strb;
  logic [IDX_W-1:0] rxIdx;
  logic [IDX_W-1:0] txIdx;

  i2sFramerCtrl #(
    .CHANNELS(CHANNELS), .LINES(LINES), .SLOT_BITS(SLOT_BITS),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) ctrl_i (
    .bclk(bclk), .rstN(rstN), .ws(ws), .parMode(parMode),
    .strb(strb), .rxIdx(rxIdx), .txIdx(txIdx), .frameValid(frameValid)
  );

  i2sFramerDatapath #(
    .CHANNELS(CHANNELS), .LINES(LINES), .SLOT_BITS(SLOT_BITS),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .CH_W(CH_W)
  ) dp_i (
    .bclk(bclk), .rstN(rstN), .parMode(parMode), .strb(strb),
    .rxIdx(rxIdx), .txIdx(txIdx), .sdIn(sdIn), .txWords(txWords),
    .muteMask(cfgWord[CHANNELS+1:2]), .outEnable(cfgWord[0]),
    .rxWords(rxWords), .sdOut(sdOut), .sdOutEn(sdOutEn)
  );

  assign driveStrong = cfgWord[1];

endmodule

// File: rtl/i2sFramerChk.sv
module i2sFramerChk #(
  parameter int CHANNELS  = 8,
  parameter int LINES     = 4,
  parameter int SLOT_BITS = 32
) (
  input logic                          bclk,
  input logic                          rstN,
  input logic                          ws,
  input logic                          parMode,
  input logic [CHANNELS*SLOT_BITS-1:0] rxWords,
  input logic                          frameValid,
  input logic [LINES-1:0]              sdOut,
  input logic [LINES-1:0]              sdOutEn
);

  // R5
  fv_pulse_chk: assert property (@(posedge bclk) disable iff (!rstN)
    frameValid |=> !frameValid);

  // R2
  fv_align_chk: assert property (@(posedge bclk) disable iff (!rstN)
    frameValid |-> (!$past(ws) && $past(ws, 2)));

  // R5
  rx_hold_chk: assert property (@(posedge bclk) disable iff (!rstN)
    !frameValid |-> $stable(rxWords));

  // R10
  serial_quiet_chk: assert property (@(posedge bclk) disable iff (!rstN)
    !parMode |-> (sdOut[LINES-1:1] == '0));

  // R8
  oe_off_chk: assert property (@(posedge bclk) disable iff (!rstN)
    (sdOutEn == '0) |-> (sdOut == '0));

  // R8
  oe_uniform_chk: assert property (@(posedge bclk) disable iff (!rstN)
    (sdOutEn == '0) || (sdOutEn == '1));

endmodule

bind i2sChannelFramer i2sFramerChk #(
  .CHANNELS(CHANNELS), .LINES(LINES), .SLOT_BITS(SLOT_BITS)
) chk_i (
  .bclk(bclk), .rstN(rstN), .ws(ws), .parMode(parMode),
  .rxWords(rxWords), .frameValid(frameValid),
  .sdOut(sdOut), .sdOutEn(sdOutEn)
);

// File: tb/i2sChannelFramer_tb_top.sv
module i2sChannelFramer_tb_top;

  logic         bclk = 1'b0;
  logic         rstN;
  logic         ws;
  logic [3:0]   sdIn;
  logic         parMode;
  logic [9:0]   cfgWord;
  logic [255:0] txWords;
  logic [255:0] rxWords;
  logic         frameValid;
  logic [3:0]   sdOut;
  logic [3:0]   sdOutEn;
  logic         driveStrong;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #5 bclk = ~bclk;

  i2sChannelFramer dut_i (
    .bclk(bclk), .rstN(rstN), .ws(ws), .sdIn(sdIn), .parMode(parMode),
    .cfgWord(cfgWord), .txWords(txWords), .rxWords(rxWords),
    .frameValid(frameValid), .sdOut(sdOut), .sdOutEn(sdOutEn),
    .driveStrong(driveStrong)
  );

  // ---- reference stimulus and model ----
  function automatic logic [31:0] rxPat(input int f, input int ch);
    if (f == 0 && ch == 0) return 32'hFFFF_FFFF;
    if (f == 0 && ch == 1) return 32'h0000_0000;
    if (f == 0 && ch == 2) return 32'h8000_0001;
    return 32'((f + 3) * 32'h9E37_79B9) ^ 32'((ch + 1) * 32'h85EB_CA6B) ^ 32'(ch << 8 | f);
  endfunction

  function automatic logic [31:0] txPat(input int f, input int ch);
    return rxPat(f + 7, ch) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [7:0] muteOf(input int f);
    case (f)
      1: return 8'h01;
      2: return 8'hA5;
      3: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [255:0] packTx(input int f);
    logic [255:0] v;
    for (int c = 0; c < 8; c++) v[c*32 +: 32] = txPat(f, c);
    return v;
  endfunction

  function automatic logic [255:0] packRx(input int f);
    logic [255:0] v;
    for (int c = 0; c < 8; c++) v[c*32 +: 32] = rxPat(f, c);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runMode(input bit par, input int nFrames);
    int L = par ? 64 : 256;
    rstN = 1'b0; parMode = par; ws = 1'b0; sdIn = '0;
    cfgWord = 10'b00_0000_0001; txWords = '0;
    repeat (3) @(negedge bclk);
    #2;
    // R1 reset state
    check(rxWords == '0, "R1 rxWords in reset", rxWords, '0);
    check(frameValid == 1'b0, "R1 frameValid in reset", 256'(frameValid), '0);
    check(sdOut == '0, "R1 sdOut in reset", 256'(sdOut), '0);
    rstN = 1'b1;
    for (int f = -1; f <= nFrames; f++) begin
      for (int p = 0; p < L; p++) begin
        int ch;
        logic [3:0] expOut;
        logic [7:0] mu;
        @(negedge bclk);
        if (p == 10) begin
          txWords = packTx(f + 1);
          cfgWord[9:2] = muteOf(f + 1);
          cfgWord[1] = 1'((f + 1) & 1);
          if (f == 2) cfgWord[0] = 1'b0;
          if (f == 3) cfgWord[0] = 1'b1;
        end
        ws = ((p + 1) % L) >= (L / 2);
        for (int l = 0; l < 4; l++) begin
          if (par) sdIn[l] = rxPat(f, 2 * l + (p >> 5))[31 - (p & 31)];
          else if (l == 0) sdIn[l] = rxPat(f, p >> 5)[31 - (p & 31)];
          else sdIn[l] = 1'($urandom);  // R3: junk on unused lines
        end
        #2;
        // transmit model: frame f sends what was latched at its start
        mu = muteOf(f);
        expOut = '0;
        if (f >= 0) begin
          for (int l = 0; l < 4; l++) begin
            if (par || l == 0) begin
              ch = par ? 2 * l + (p >> 5) : (p >> 5);
              if (!mu[ch]) expOut[l] = txPat(f, ch)[31 - (p & 31)];
            end
          end
        end
        if (!cfgWord[0]) expOut = '0;
        check(sdOut == expOut,
              !cfgWord[0] ? "R8 sdOut disabled" : (mu != 0 ? "R7 muted tx" :
              (par ? "R6 parallel tx" : "R6 R10 serial tx")),
              256'(sdOut), 256'(expOut));
        check(sdOutEn == {4{cfgWord[0]}}, "R8 sdOutEn", 256'(sdOutEn), 256'({4{cfgWord[0]}}));
        check(driveStrong == cfgWord[1], "R9 driveStrong", 256'(driveStrong), 256'(cfgWord[1]));
        if (p == 0) begin
          check(frameValid == (f >= 1), "R5 R1 strobe at boundary",
                256'(frameValid), 256'(f >= 1));
          if (f >= 1)
            check(rxWords == packRx(f - 1), par ? "R4 R2 parallel rx" : "R3 R2 serial rx",
                  rxWords, packRx(f - 1));
        end else begin
          check(frameValid == 1'b0, "R5 no strobe mid-frame", 256'(frameValid), '0);
        end
        if (p == L / 2) begin
          if (f >= 1) check(rxWords == packRx(f - 1), "R5 rx held", rxWords, packRx(f - 1));
          else        check(rxWords == '0, "R1 rx before first frame", rxWords, '0);
        end
      end
    end
  endtask

  initial begin
    fork
      begin
        runMode(1'b0, 5);
        runMode(1'b1, 5);
      end
      begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

endmodule